// File: doc/BRIEF.md
# Serial Transmit Mode and Self-Test Controller

This block is the control and shifting stage on the transmit side of a serial link. Each word period it takes one 10-bit word and shifts it out one bit per bit clock, least significant bit first. A free-running divide-by-ten bit counter sets the word period. The counter decides when the next word moves into the shifter and when the word-boundary pulse appears. The block runs on the bit clock only. The word-rate timing is derived from the counter, so the word rate is always exactly one tenth of the bit rate and keeps a fixed phase.

A mode input picks where the next word comes from:
- **Bypass:** a raw 10-bit word from the stream input.
- **Encoded:** a 10-bit code returned by an external 8B/10B encoder. The block drives the encoder's 8-bit data and control inputs and reads its code output on the same cycle.
- **Test:** behaves exactly like encoded.

Pulling the active-low self-test input low forces encoded operation in every mode. The stream is then replaced by an 8-bit pseudo-random pattern fed to the encoder. Releasing the input returns the block to the selected mode, including bypass.

Stream rules: `in_ready` is high only in the last bit period of a word (bit counter = 9), and only while self-test is off. A word is taken when `in_valid` and `in_ready` are both high in that cycle. The producer must hold its word until then. If nothing is taken, an all-zero idle word is sent.

Top module: `ser_tx_ctrl`

## Requirements
- R1: Synchronous reset clears the bit counter to 0 and loads the shifter with an all-zero word. In the first cycle after reset, `ser_out` is 0 and `word_sync` is 1.
- R2: The bit counter runs 0 to 9 and wraps to 0. `word_sync` is high exactly while the counter is 0, for one bit clock in every ten.
- R3: With mode = 2'b01 (bypass) and self-test off, a word accepted from `in_raw` is loaded into the shifter unchanged at the 9 to 0 counter transition.
- R4: With mode = 2'b00 (encoded) and self-test off, `enc_in_data`/`enc_in_ctrl` follow `in_data`/`in_ctrl`. When a word is accepted, `enc_code` is loaded at the 9 to 0 transition.
- R5: With mode = 2'b10 or 2'b11 (test), the block behaves exactly as in encoded mode.
- R6: While `bist_n` is 0, `in_ready` stays 0 in every mode, including bypass. At each 9 to 0 transition `enc_code` is loaded, with `enc_in_ctrl` = 0 and `enc_in_data` = the pattern register.
- R7: When `bist_n` returns to 1 with bypass selected, raw words are loaded again from the next accepted word onward.
- R8: While `bist_n` is 1, the pattern register holds seed 8'hA5. While `bist_n` is 0, it advances at each 9 to 0 transition by one step: shift left, with the new bit 0 = b7^b5^b4^b3.
- R9: `in_ready` is 1 exactly when the counter is 9 and `bist_n` is 1. A word is taken only in a cycle where `in_valid` and `in_ready` are both 1.
- R10: If no word is taken at a 9 to 0 transition and self-test is off, the all-zero idle word is loaded.
- R11: `ser_out` presents bit 0 of the loaded word in counter state 0 and bit k in counter state k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 encoded, 01 bypass, 1x test |
| bist_n | input | 1 | Self-test enable, active low |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted this cycle if valid |
| in_raw | input | 10 | Raw word used in bypass |
| in_data | input | 8 | Data byte used in encoded/test mode |
| in_ctrl | input | 1 | Special-character flag used in encoded/test mode |
| enc_in_data | output | 8 | Byte to external encoder |
| enc_in_ctrl | output | 1 | Control flag to external encoder |
| enc_code | input | 10 | Code word from external encoder |
| ser_out | output | 1 | Serial bit, LSB first |
| word_sync | output | 1 | Word-boundary pulse, high in counter state 0 |

## Verification
The hardest situation to reach from the ports is the switch from self-test back to bypass in the middle of a word. It must leave the in-flight pattern word intact, start raw words at the next boundary, and restart the pattern from its seed on the next entry. The bench toggles `bist_n` and `mode` at cycles that are not word boundaries, while a stream with gaps keeps offering words. A behavioural model built from a bit queue and an integer counter is compared with every output on every bit clock.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    MODE_ENC  = 2'b00,
    MODE_BYP  = 2'b01,
    MODE_TST  = 2'b10,
    MODE_TST2 = 2'b11
  } tx_mode_e;

  function automatic logic raw_path(input logic [1:0] m);
    return m == MODE_BYP;
  endfunction
endpackage

// File: rtl/ser_bitcnt.sv
module ser_bitcnt #(
  parameter int WORD_W = 10,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             sync
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST);
  assign sync = (cnt == '0);

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    last |=> (cnt == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !last |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ser_pattern.sv
module ser_pattern #(
  parameter int          PAT_W = 8,
  parameter logic [PAT_W-1:0] SEED = 8'hA5,
  parameter logic [PAT_W-1:0] TAPS = 8'hB8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             step,
  output logic [PAT_W-1:0] pat
);
  logic fb;
  assign fb = ^(pat & TAPS);

  always_ff @(posedge clk) begin
    if (rst || !active) pat <= SEED;
    else if (step)      pat <= {pat[PAT_W-2:0], fb};
  end

  p_seed_r8: assert property (@(posedge clk) disable iff (rst)
    !active |=> (pat == SEED));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !step) |=> (pat == $past(pat)));
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              sout
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= word;
    else           sh <= {1'b0, sh[WORD_W-1:1]};
  end

  assign sout = sh[0];

  p_shift_r11: assert property (@(posedge clk) disable iff (rst)
    !load |=> (sh == ($past(sh) >> 1)));
  p_load_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> (sout == $past(word[0])));
endmodule

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl #(
  parameter int          WORD_W = 10,
  parameter int          DATA_W = 8,
  parameter logic [DATA_W-1:0] SEED = 8'hA5,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              bist_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_raw,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctrl,
  output logic [DATA_W-1:0] enc_in_data,
  output logic              enc_in_ctrl,
  input  logic [WORD_W-1:0] enc_code,
  output logic              ser_out,
  output logic              word_sync
);
  import ser_tx_pkg::*;

  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic              bist_on;
  logic              take;
  logic [DATA_W-1:0] pat;
  logic [WORD_W-1:0] next_word;

  assign bist_on = !bist_n;

  ser_bitcnt #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt), .last(last), .sync(word_sync)
  );

  ser_pattern #(.PAT_W(DATA_W), .SEED(SEED)) u_pat (
    .clk(clk), .rst(rst), .active(bist_on), .step(last), .pat(pat)
  );

  assign in_ready    = last && !bist_on;
  assign take        = in_valid && in_ready;
  assign enc_in_data = bist_on ? pat : in_data;
  assign enc_in_ctrl = bist_on ? 1'b0 : in_ctrl;

  always_comb begin
    if (bist_on)                next_word = enc_code;
    else if (!take)             next_word = '0;
    else if (raw_path(mode))    next_word = in_raw;
    else                        next_word = enc_code;
  end

  ser_shifter #(.WORD_W(WORD_W)) u_sh (
    .clk(clk), .rst(rst), .load(last), .word(next_word), .sout(ser_out)
  );

  p_no_ready_bist_r6: assert property (@(posedge clk) disable iff (rst)
    bist_on |-> !in_ready);
  p_ready_edge_r9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> word_sync == 1'b0 && $past(cnt) == CNT_W'(WORD_W - 2));
  p_bist_ctrl_r6: assert property (@(posedge clk) disable iff (rst)
    bist_on |-> !enc_in_ctrl);
endmodule

// File: tb/tb_ser_tx_ctrl.sv
module tb_ser_tx_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic bist_n = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [9:0] in_raw = '0;
  logic [7:0] in_data = '0;
  logic in_ctrl = 1'b0;
  logic [7:0] enc_in_data;
  logic enc_in_ctrl;
  logic [9:0] enc_code;
  logic ser_out;
  logic word_sync;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  function automatic logic [9:0] enc_f(input logic [7:0] d, input logic c);
    return {c, ~c, d} ^ 10'h2A5;
  endfunction

  assign enc_code = enc_f(enc_in_data, enc_in_ctrl);

  ser_tx_ctrl dut (
    .clk(clk), .rst(rst), .mode(mode), .bist_n(bist_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_raw(in_raw),
    .in_data(in_data), .in_ctrl(in_ctrl), .enc_in_data(enc_in_data),
    .enc_in_ctrl(enc_in_ctrl), .enc_code(enc_code), .ser_out(ser_out),
    .word_sync(word_sync)
  );

  // reference model
  int mcnt = 0;
  bit q[$];
  logic [7:0] lf = 8'hA5;

  always @(posedge clk) begin
    logic [9:0] w;
    logic [7:0] lf_next;
    logic rdy;
    cyc++;
    if (rst) begin
      mcnt = 0;
      q = {};
      for (int i = 0; i < 10; i++) q.push_back(1'b0);
      lf = 8'hA5;
    end else begin
      lf_next = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (mcnt == 9) begin
        rdy = bist_n;
        if (!bist_n) w = enc_f(lf, 1'b0);
        else if (!(in_valid && rdy)) w = '0;
        else if (mode == 2'b01) w = in_raw;
        else w = enc_f(in_data, in_ctrl);
        q = {};
        for (int i = 0; i < 10; i++) q.push_back(w[i]);
        mcnt = 0;
      end else begin
        void'(q.pop_front());
        mcnt++;
      end
      if (bist_n) lf = 8'hA5;
      else if (mcnt == 0) lf = lf_next;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk({tag, "/R11 ser_out"}, ser_out, q[0]);
    chk("R2 word_sync", word_sync, mcnt == 0);
    chk("R9 in_ready", in_ready, (mcnt == 9) && bist_n);
    if (!bist_n) begin
      chk8("R8 pattern", enc_in_data, lf);
      chk("R6 enc_in_ctrl", enc_in_ctrl, 1'b0);
    end else begin
      chk8("R4 enc_in_data", enc_in_data, in_data);
      chk("R4 enc_in_ctrl", enc_in_ctrl, in_ctrl);
    end
  endtask

  // one bit clock: drive at negedge, compare 1 ns later
  task automatic step(input int gap);
    @(negedge clk);
    in_raw  = in_raw + 10'h13B;
    in_data = in_data + 8'h2D;
    in_ctrl = in_data[2];
    if (!in_valid || in_ready) in_valid = (gap == 0) ? 1'b1 : ((cyc % gap) != 0);
    #1;
    if (!rst) compare();
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) step(gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    tag = "R1";
    chk("R1 ser_out after reset", ser_out, 1'b0);
    chk("R1 word_sync after reset", word_sync, 1'b1);
    tag = "R10"; run(25, 1);
    in_valid = 1'b0;
    tag = "R4"; mode = 2'b00; run(120, 3);
    tag = "R3"; mode = 2'b01; run(120, 0);
    tag = "R5"; mode = 2'b10; run(60, 4);
    mode = 2'b11; run(60, 0);
    tag = "R6"; mode = 2'b01; run(3, 0); bist_n = 1'b0; run(97, 0);
    tag = "R7"; bist_n = 1'b1; run(80, 2);
    tag = "R8"; bist_n = 1'b0; run(47, 0);
    tag = "R6"; mode = 2'b00; run(60, 0);
    tag = "R7"; mode = 2'b01; bist_n = 1'b1; run(60, 0);
    tag = "R1"; rst = 1'b1; run(4, 0); rst = 1'b0; #1;
    chk("R1 word_sync after re-reset", word_sync, 1'b1);
    chk("R1 ser_out after re-reset", ser_out, 1'b0);
    tag = "R3"; run(40, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #80000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule